// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Periodic Refresh

This block sits between a host and an asynchronous-style DRAM array. The host hands it a read or write request carrying a full word address. The controller splits that address into an upper row part and a lower column part. Both parts go out on one shared, half-width address bus: the row first, latched by the row strobe, then the column, latched by the column strobe. Writes drive data with the write enable asserted. Reads assert the output enable, sample the array's data a fixed number of cycles after the column strobe falls, and return the word on a response port. Every access ends with a precharge period in which both strobes are high.

An interval timer raises a refresh request every `REF_PERIOD` cycles. The controller serves it with a row-strobe-only cycle on the row named by an internal refresh row counter. The counter steps by one after each refresh and wraps at the number of rows. A pending refresh wins over a new host request, but it never cuts short an access that has already started. A request that arrives during a refresh waits for it to finish. A plain status output reports idle, access or refresh. All array timings are whole clock cycles set by parameters.

The request port is valid/ready. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and `req_ready` is low, the host must hold `req_write`, `req_addr` and `req_wdata` steady. The read response has no back-pressure: `rsp_valid` is a one-cycle pulse that the host must take.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `mem_ras_n`, `mem_cas_n`, `mem_we_n` and `mem_oe_n` are 1, and `mem_dq_oe` and `rsp_valid` are 0. `status` is 0 (idle) and `req_ready` is 1.
- R2: In every access, the row strobe falls with the row (address bits [ADDR_W-1:COL_W]) on `mem_addr`. The column strobe falls exactly `T_RCD` cycles later, with the column (bits [COL_W-1:0]) on `mem_addr`, and only while the row strobe is low.
- R3: In a write access, `mem_we_n` is 0 and `mem_dq_oe` is 1 while the column strobe is low, and `mem_dq_out` carries the request's data. A later read of the same address returns that data.
- R4: In a read access, `mem_oe_n` is 0 while the column strobe is low, and `mem_we_n` stays 1. The controller samples `mem_dq_in` in the `T_CAC`-th cycle of the column strobe. It returns that value on `rsp_data` with a one-cycle `rsp_valid` pulse on the next cycle.
- R5: After the row strobe rises, it stays high for at least `T_RP` cycles before it falls again.
- R6: A refresh holds the row strobe low for exactly `T_RFSH` cycles while the column strobe stays high.
- R7: The first refresh after reset uses row 0. Each later refresh uses the previous row plus one, wrapping from 2^(ADDR_W-COL_W)-1 to 0.
- R8: A pending refresh is served before a waiting host request. `req_ready` is 0 whenever `status` is not idle. A request held during a refresh is accepted after it ends.
- R9: Consecutive refresh row-strobe falls are never more than `REF_PERIOD + T_RCD + T_CAC + T_RP + 2` cycles apart. The first one comes no later than that after reset.
- R10: `status` is 0 when idle, 1 from the acceptance edge of a request until its precharge ends, and 2 during a refresh and its precharge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Full word address, row in the upper bits |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_data | output | DATA_W | Read data |
| mem_addr | output | max(ADDR_W-COL_W, COL_W) | Shared row/column address bus |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Data toward the array |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | DATA_W | Data from the array |
| status | output | 2 | 0 idle, 1 access, 2 refresh |

## Verification
The refresh timer and the host request port can demand the array in the same cycle. The bench provokes this by sending back-to-back write/read pairs for many refresh periods, so timer expiries land both while an access is running and while a new request is waiting. A behavioural array model counts strobe widths and the gaps between refreshes. It records every cycle in which a request is held while `status` shows refresh, requires `req_ready` to be low there, and requires each waiting request to finish later with correct data. The bench fails the run if no such collision occurred.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [2:0] {
    F_IDLE  = 3'd0,
    F_ROW   = 3'd1,
    F_COL   = 3'd2,
    F_PRE_A = 3'd3,
    F_RFSH  = 3'd4,
    F_PRE_R = 3'd5
  } fsm_e;

  localparam logic [1:0] STAT_IDLE    = 2'd0;
  localparam logic [1:0] STAT_ACCESS  = 2'd1;
  localparam logic [1:0] STAT_REFRESH = 2'd2;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int PERIOD = 780,
  parameter int ROW_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_start,
  input  logic             ref_done,
  output logic             ref_pend,
  output logic [ROW_W-1:0] ref_row
);
  localparam int TW       = $clog2(PERIOD);
  localparam int ROWS     = 1 << ROW_W;
  localparam logic [TW-1:0]    LAST_TICK = TW'(PERIOD - 1);
  localparam logic [ROW_W-1:0] LAST_ROW  = ROW_W'(ROWS - 1);

  logic [TW-1:0] tick;
  logic          fire;

  assign fire = (tick == LAST_TICK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tick <= '0;
    else if (fire) tick <= '0;
    else           tick <= tick + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ref_pend <= 1'b0;
    else if (fire)      ref_pend <= 1'b1;
    else if (ref_start) ref_pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ref_row <= '0;
    else if (ref_done) ref_row <= (ref_row == LAST_ROW) ? '0 : ref_row + 1'b1;
  end

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
  import dram_ctrl_pkg::*;
#(
  parameter int T_RCD  = 2,
  parameter int T_CAC  = 2,
  parameter int T_RP   = 2,
  parameter int T_RFSH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  input  logic ref_pend,
  output fsm_e state,
  output logic wr_q,
  output logic req_ready,
  output logic accept,
  output logic ref_start,
  output logic ref_done,
  output logic rd_capture
);
  localparam int MAXT = max_of(max_of(T_RCD, T_CAC), max_of(T_RP, T_RFSH));
  localparam int CW   = $clog2(MAXT + 1);

  logic [CW-1:0] cnt;
  logic          cnt_zero;

  assign cnt_zero   = (cnt == '0);
  assign req_ready  = (state == F_IDLE) && !ref_pend;
  assign accept     = req_valid && req_ready;
  assign ref_start  = (state == F_IDLE) && ref_pend;
  assign ref_done   = (state == F_RFSH) && cnt_zero;
  assign rd_capture = (state == F_COL) && cnt_zero && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= F_IDLE;
      cnt   <= '0;
      wr_q  <= 1'b0;
    end else begin
      unique case (state)
        F_IDLE: begin
          if (ref_pend) begin
            state <= F_RFSH;
            cnt   <= CW'(T_RFSH - 1);
          end else if (req_valid) begin
            state <= F_ROW;
            cnt   <= CW'(T_RCD - 1);
            wr_q  <= req_write;
          end
        end
        F_ROW: begin
          if (cnt_zero) begin
            state <= F_COL;
            cnt   <= CW'(T_CAC - 1);
          end else cnt <= cnt - 1'b1;
        end
        F_COL: begin
          if (cnt_zero) begin
            state <= F_PRE_A;
            cnt   <= CW'(T_RP - 1);
          end else cnt <= cnt - 1'b1;
        end
        F_RFSH: begin
          if (cnt_zero) begin
            state <= F_PRE_R;
            cnt   <= CW'(T_RP - 1);
          end else cnt <= cnt - 1'b1;
        end
        F_PRE_A, F_PRE_R: begin
          if (cnt_zero) state <= F_IDLE;
          else          cnt   <= cnt - 1'b1;
        end
        default: begin
          state <= F_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/dram_addr_path.sv
module dram_addr_path
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  parameter int PIN_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   accept,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  fsm_e                   state,
  input  logic [ROW_W-1:0]       ref_row,
  input  logic                   rd_capture,
  input  logic [DATA_W-1:0]      mem_dq_in,
  output logic [PIN_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]      mem_dq_out,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_data
);
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      row_q   <= req_addr[ROW_W+COL_W-1:COL_W];
      col_q   <= req_addr[COL_W-1:0];
      wdata_q <= req_wdata;
    end
  end

  always_comb begin
    unique case (state)
      F_ROW:   mem_addr = PIN_W'(row_q);
      F_COL:   mem_addr = PIN_W'(col_q);
      F_RFSH:  mem_addr = PIN_W'(ref_row);
      default: mem_addr = '0;
    endcase
  end

  assign mem_dq_out = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_capture;
      if (rd_capture) rsp_data <= mem_dq_in;
    end
  end

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import dram_ctrl_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int COL_W      = 8,
  parameter int DATA_W     = 16,
  parameter int T_RCD      = 2,
  parameter int T_CAC      = 2,
  parameter int T_RP       = 2,
  parameter int T_RFSH     = 3,
  parameter int REF_PERIOD = 780,
  localparam int ROW_W     = ADDR_W - COL_W,
  localparam int PIN_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [PIN_W-1:0]  mem_addr,
  output logic              mem_ras_n,
  output logic              mem_cas_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic [1:0]        status
);
  fsm_e             state;
  logic             wr_q;
  logic             accept;
  logic             ref_pend;
  logic             ref_start;
  logic             ref_done;
  logic             rd_capture;
  logic [ROW_W-1:0] ref_row;

  dram_refresh_timer #(
    .PERIOD (REF_PERIOD),
    .ROW_W  (ROW_W)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_start (ref_start),
    .ref_done  (ref_done),
    .ref_pend  (ref_pend),
    .ref_row   (ref_row)
  );

  dram_seq_fsm #(
    .T_RCD  (T_RCD),
    .T_CAC  (T_CAC),
    .T_RP   (T_RP),
    .T_RFSH (T_RFSH)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .ref_pend   (ref_pend),
    .state      (state),
    .wr_q       (wr_q),
    .req_ready  (req_ready),
    .accept     (accept),
    .ref_start  (ref_start),
    .ref_done   (ref_done),
    .rd_capture (rd_capture)
  );

  dram_addr_path #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W),
    .PIN_W  (PIN_W)
  ) u_path (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .state      (state),
    .ref_row    (ref_row),
    .rd_capture (rd_capture),
    .mem_dq_in  (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_dq_out (mem_dq_out),
    .rsp_valid  (rsp_valid),
    .rsp_data   (rsp_data)
  );

  // Strobes are decoded from registered state only.
  assign mem_ras_n = !((state == F_ROW) || (state == F_COL) || (state == F_RFSH));
  assign mem_cas_n = !(state == F_COL);
  assign mem_we_n  = !((state == F_COL) && wr_q);
  assign mem_oe_n  = !((state == F_COL) && !wr_q);
  assign mem_dq_oe = (state == F_COL) && wr_q;

  always_comb begin
    unique case (state)
      F_ROW, F_COL, F_PRE_A: status = STAT_ACCESS;
      F_RFSH, F_PRE_R:       status = STAT_REFRESH;
      default:               status = STAT_IDLE;
    endcase
  end

endmodule

// File: rtl/dram_refresh_ctrl_chk.sv
module dram_refresh_ctrl_chk #(
  parameter int ADDR_W     = 16,
  parameter int COL_W      = 8,
  parameter int T_RCD      = 2,
  parameter int T_CAC      = 2,
  parameter int T_RP       = 2,
  parameter int REF_PERIOD = 780,
  localparam int ROW_W     = ADDR_W - COL_W,
  localparam int PIN_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             rsp_valid,
  input logic [PIN_W-1:0] mem_addr,
  input logic             mem_ras_n,
  input logic             mem_cas_n,
  input logic             mem_oe_n,
  input logic [1:0]       status
);
  localparam int GAP_MAX = REF_PERIOD + T_RCD + T_CAC + T_RP + 2;
  localparam int GW      = $clog2(GAP_MAX + 8) + 1;
  localparam int LW      = $clog2(T_RCD + T_RP + 8) + 1;
  localparam logic [LW-1:0] LSAT = {LW{1'b1}};

  logic [LW-1:0]    lo_cnt;
  logic [LW-1:0]    hi_cnt;
  logic [GW-1:0]    gap_cnt;
  logic [ROW_W-1:0] exp_row;
  logic             ref_fall;

  assign ref_fall = !mem_ras_n && (hi_cnt != '0) && (status == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt  <= '0;
      hi_cnt  <= LW'(T_RP);
      gap_cnt <= '0;
      exp_row <= '0;
    end else begin
      lo_cnt  <= mem_ras_n ? '0 : ((lo_cnt == LSAT) ? lo_cnt : lo_cnt + 1'b1);
      hi_cnt  <= !mem_ras_n ? '0 : ((hi_cnt == LSAT) ? hi_cnt : hi_cnt + 1'b1);
      gap_cnt <= ref_fall ? '0 : gap_cnt + 1'b1;
      if (ref_fall) exp_row <= exp_row + 1'b1;
    end
  end

  // R2
  cas_after_rcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cas_n) |-> (!mem_ras_n && lo_cnt == LW'(T_RCD)));

  // R4
  rsp_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(!mem_oe_n));

  // R5
  precharge_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ras_n) |-> (hi_cnt >= LW'(T_RP)));

  // R6
  refresh_no_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'd2) |-> mem_cas_n);

  // R7
  refresh_row_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_fall |-> (mem_addr == PIN_W'(exp_row)));

  // R8
  ready_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (status == 2'd0));

  // R9
  refresh_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gap_cnt <= GW'(GAP_MAX));

endmodule

bind dram_refresh_ctrl dram_refresh_ctrl_chk #(
  .ADDR_W     (ADDR_W),
  .COL_W      (COL_W),
  .T_RCD      (T_RCD),
  .T_CAC      (T_CAC),
  .T_RP       (T_RP),
  .REF_PERIOD (REF_PERIOD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .mem_addr  (mem_addr),
  .mem_ras_n (mem_ras_n),
  .mem_cas_n (mem_cas_n),
  .mem_oe_n  (mem_oe_n),
  .status    (status)
);

// File: tb/dram_refresh_ctrl_tb.sv
module dram_refresh_ctrl_tb;
  localparam int ADDR_W = 8, COL_W = 4, DATA_W = 8;
  localparam int T_RCD = 2, T_CAC = 3, T_RP = 2, T_RFSH = 3, REF_PERIOD = 40;
  localparam int GAP_MAX = REF_PERIOD + T_RCD + T_CAC + T_RP + 2;
  localparam int WD_LIMIT = 100000;
  localparam int NVEC = 14;
  // bit 16: write, [15:8]: address, [7:0]: write data or expected read data
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 8'h00, 8'h11}, {1'b1, 8'hFF, 8'hEE}, {1'b1, 8'h5A, 8'h3C},
    {1'b1, 8'h50, 8'h77}, {1'b1, 8'hA5, 8'hC3}, {1'b1, 8'h0F, 8'hF0},
    {1'b0, 8'h00, 8'h11}, {1'b0, 8'hFF, 8'hEE}, {1'b0, 8'h5A, 8'h3C},
    {1'b0, 8'h50, 8'h77}, {1'b0, 8'hA5, 8'hC3}, {1'b0, 8'h0F, 8'hF0},
    {1'b1, 8'h5A, 8'h99}, {1'b0, 8'h5A, 8'h99}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [DATA_W-1:0] rsp_data, mem_dq_out, mem_dq_in;
  logic [3:0] mem_addr;
  logic [1:0] status;

  int nchk = 0, nerr = 0, cyc = 0;

  always #2 clk = ~clk;

  dram_refresh_ctrl #(
    .ADDR_W(ADDR_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .T_CAC(T_CAC),
    .T_RP(T_RP), .T_RFSH(T_RFSH), .REF_PERIOD(REF_PERIOD)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_addr(mem_addr),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .status(status)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD_LIMIT) begin
      chk(1'b0, "watchdog", cyc, WD_LIMIT);
      finish_run();
    end
  end

  // ---------------- behavioural array model and port monitor ----------------
  logic [DATA_W-1:0] dmem [256];
  logic [3:0] row_l = '0;
  int ras_lo = 0, ras_hi = 100, cas_cnt = 0, fall_cyc = 0, last_ref = 0, mcyc = 0;
  int nref = 0, ncoll = 0;
  logic ras_prev = 1'b1, cas_prev = 1'b1, saw_cas = 1'b0;
  logic [3:0] exp_ref = '0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [DATA_W-1:0] acc_data = '0;

  assign mem_dq_in = (!mem_cas_n && !mem_oe_n && cas_cnt >= T_CAC) ?
                     dmem[{row_l, mem_addr}] : ~dmem[{row_l, mem_addr}];

  initial for (int i = 0; i < 256; i++) dmem[i] = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      mcyc++;
      if (req_valid && req_ready) begin
        acc_addr = req_addr;
        acc_data = req_wdata;
      end
      if (!mem_ras_n && ras_prev) begin
        chk(ras_hi >= T_RP, "R5 precharge", ras_hi, T_RP);
        row_l = mem_addr;
        fall_cyc = mcyc;
        saw_cas = 1'b0;
      end
      if (!mem_cas_n && cas_prev) begin
        saw_cas = 1'b1;
        chk(row_l == acc_addr[7:4], "R2 row", row_l, acc_addr[7:4]);
        chk(mem_addr == acc_addr[3:0], "R2 column", mem_addr, acc_addr[3:0]);
        chk(ras_lo == T_RCD, "R2 ras-to-cas", ras_lo, T_RCD);
        if (!mem_we_n) begin
          chk(mem_dq_oe && mem_oe_n, "R3 drive", {mem_dq_oe, mem_oe_n}, 2'b11);
          chk(mem_dq_out == acc_data, "R3 data", mem_dq_out, acc_data);
          dmem[{row_l, mem_addr}] = mem_dq_out;
        end else begin
          chk(!mem_oe_n && !mem_dq_oe, "R4 output enable", {mem_oe_n, mem_dq_oe}, 2'b00);
        end
      end
      if (mem_ras_n && !ras_prev && !saw_cas) begin
        chk(ras_lo == T_RFSH, "R6 refresh width", ras_lo, T_RFSH);
        chk(row_l == exp_ref, "R7 refresh row", row_l, exp_ref);
        chk(status == 2'd2, "R10 refresh status", status, 2);
        chk(fall_cyc - last_ref <= GAP_MAX, "R9 refresh gap", fall_cyc - last_ref, GAP_MAX);
        last_ref = fall_cyc;
        exp_ref = exp_ref + 4'd1;
        nref++;
      end
      if (status != 2'd0) chk(!req_ready, "R8 ready while busy", req_ready, 0);
      if (req_valid && status == 2'd2) ncoll++;
      ras_lo  = mem_ras_n ? 0 : ras_lo + 1;
      ras_hi  = mem_ras_n ? ras_hi + 1 : 0;
      cas_cnt = mem_cas_n ? 0 : cas_cnt + 1;
      ras_prev = mem_ras_n;
      cas_prev = mem_cas_n;
    end
  end

  // ---------------- host side ----------------
  task automatic do_op(input bit wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    int wt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready && wt < 200) begin
      @(negedge clk);
      wt++;
    end
    @(negedge clk);
    req_valid = 1'b0;
    chk(status == 2'd1, "R10 access status", status, 1);
    if (!wr) begin
      wt = 0;
      while (!rsp_valid && wt < 50) begin
        @(negedge clk);
        wt++;
      end
      chk(rsp_valid, "R4 response", rsp_valid, 1);
      chk(rsp_data == d, wr ? "R3 readback" : "R4 read data", rsp_data, d);
      @(negedge clk);
      chk(!rsp_valid, "R4 single pulse", rsp_valid, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    chk({mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n} == 4'hF, "R1 strobes", {mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n}, 4'hF);
    chk(!mem_dq_oe && !rsp_valid, "R1 drive/rsp", {mem_dq_oe, rsp_valid}, 0);
    chk(status == 2'd0 && req_ready, "R1 status/ready", {status, req_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);
    chk({mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n} == 4'hF, "R1 strobes after reset", {mem_ras_n, mem_cas_n, mem_we_n, mem_oe_n}, 4'hF);
    chk(status == 2'd0 && req_ready, "R1 idle after reset", {status, req_ready}, 3'b001);

    // table walk: R2, R3, R4
    for (int i = 0; i < NVEC; i++) do_op(VEC[i][16], VEC[i][15:8], VEC[i][7:0]);

    // back-to-back traffic so refresh expiries collide with requests: R8, R9
    for (int i = 0; i < 45; i++) begin
      logic [7:0] a = 8'((i * 29 + 3) % 256);
      logic [7:0] d = 8'((i * 7 + 3) % 256);
      do_op(1'b1, a, d);
      do_op(1'b0, a, d);
    end

    // idle period: refresh keeps running, row counter wraps (R7)
    repeat (8 * REF_PERIOD) @(negedge clk);
    chk(ncoll > 0, "R8 collision provoked", ncoll, 1);
    chk(nref > 16, "R7 row wrap reached", nref, 17);
    chk(nref >= (mcyc / GAP_MAX), "R9 refresh count", nref, mcyc / GAP_MAX);
    chk(mcyc - last_ref <= GAP_MAX, "R9 final gap", mcyc - last_ref, GAP_MAX);
    finish_run();
  end

endmodule